// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the interrupt status flags and the interrupt enable bits for a 16-bit timer/counter. The counter, its comparators, the prescaler and the waveform logic live elsewhere. They reach this unit only as event inputs:
- an overflow pulse;
- two compare-equal levels;
- a capture event;
- a counter-at-TOP level;
- two forced-compare strobes;
- a mode bit that makes the capture register the TOP value;
- a timer clock-enable tick.

A small register port with a single address bit reads and writes two registers. The flag register sits at address 0 and the enable register at address 1.

Each flag drives an interrupt request. A request is raised only when the flag is set, its enable bit is one and the global interrupt-enable input is one. Software clears a flag by writing a one to its bit. The CPU also clears a flag when it acknowledges that flag's vector. A set event that lands in the same cycle as a clear takes priority, so no event is lost.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset, both registers read 0x00 and all four interrupt requests are low.
- R2: Flag register (address 0) layout: overflow at bit 0, compare-A at bit 1, compare-B at bit 2, capture/TOP at bit 5. Bits 7, 6, 4 and 3 always read zero, including after a write of ones.
- R3: Enable register (address 1) layout: overflow at bit 0, compare-A at bit 1, compare-B at bit 2, capture at bit 5. A write stores those bits, and the other bits read zero.
- R4: Each request output equals its flag AND its enable bit AND `globalIe`, combinationally from the current register state.
- R5: A compare flag is set at the clock edge of the next tick after a tick cycle on which its match input was high. Cycles without a tick neither sample the match nor set the flag.
- R6: A forced-compare strobe never sets a compare flag.
- R7: The overflow flag is set at the edge that ends a cycle where `tick` and `ovfPulse` are both high. The pulse is ignored when `tick` is low.
- R8: With `capIsTop`=0, `capEvent` sets the capture flag on any cycle and `atTop` is ignored. With `capIsTop`=1, the flag is set by `atTop` on a tick cycle and `capEvent` is ignored.
- R9: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged.
- R10: An acknowledge pulse for a source clears that source's flag.
- R11: If a set event and a clear (write or acknowledge) hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addrSel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register (combinational) |
| tick | input | 1 | Timer clock-enable |
| ovfPulse | input | 1 | Counter overflow |
| matchA | input | 1 | Counter equals compare value A |
| matchB | input | 1 | Counter equals compare value B |
| forceA | input | 1 | Forced-compare strobe, channel A |
| forceB | input | 1 | Forced-compare strobe, channel B |
| capEvent | input | 1 | Capture event |
| atTop | input | 1 | Counter is at TOP |
| capIsTop | input | 1 | Capture register serves as TOP |
| globalIe | input | 1 | Global interrupt enable |
| ackOvf | input | 1 | Overflow vector acknowledge |
| ackCmpA | input | 1 | Compare-A vector acknowledge |
| ackCmpB | input | 1 | Compare-B vector acknowledge |
| ackCap | input | 1 | Capture vector acknowledge |
| irqOvf | output | 1 | Overflow interrupt request |
| irqCmpA | output | 1 | Compare-A interrupt request |
| irqCmpB | output | 1 | Compare-B interrupt request |
| irqCap | output | 1 | Capture interrupt request |

## Verification
A wrong flag or enable bit shows up on `rdData` and on the request outputs on the clock edge right after the event, write or acknowledge that caused it. A missing or extra compare pending bit is different. It surfaces only one tick later, when a compare flag appears, or fails to appear, at the following tick edge. Because of that delay, the bench compares every cycle with randomly gapped ticks against a cycle-accurate model.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NSRC  = 4;
  localparam int REG_W = 8;
  localparam int SRC_OVF  = 0;
  localparam int SRC_CMPA = 1;
  localparam int SRC_CMPB = 2;
  localparam int SRC_CAP  = 3;

  function automatic int srcBit(input int src);
    case (src)
      SRC_OVF:  return 0;
      SRC_CMPA: return 1;
      SRC_CMPB: return 2;
      default:  return 5;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] validMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[srcBit(i)] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic [NSRC-1:0] setFlag;
    logic [NSRC-1:0] clrFlag;
    logic            maskWe;
    logic [NSRC-1:0] maskVal;
  } strobes_t;
endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ovfPulse,
  input  logic             matchA,
  input  logic             matchB,
  input  logic             forceA,
  input  logic             forceB,
  input  logic             capEvent,
  input  logic             atTop,
  input  logic             capIsTop,
  input  logic             wrEn,
  input  logic             addrSel,
  input  logic [REG_W-1:0] wrData,
  input  logic [NSRC-1:0]  ack,
  output strobes_t         stb
);
  localparam logic [REG_W-1:0] VALID = validMask();

  logic pendA, pendB;
  logic flagWr;
  logic unusedIn;

  assign flagWr   = wrEn && !addrSel;
  assign unusedIn = ^{wrData & ~VALID, forceA, forceB};

  // Match conditions are captured on a tick and turn into flags on the next tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendA <= 1'b0;
      pendB <= 1'b0;
    end else if (tick) begin
      pendA <= matchA;
      pendB <= matchB;
    end
  end

  always_comb begin
    stb.setFlag[SRC_OVF]  = tick && ovfPulse;
    stb.setFlag[SRC_CMPA] = tick && pendA;
    stb.setFlag[SRC_CMPB] = tick && pendB;
    stb.setFlag[SRC_CAP]  = capIsTop ? (tick && atTop) : capEvent;
    stb.maskWe            = wrEn && addrSel;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign stb.clrFlag[i] = ack[i] || (flagWr && wrData[srcBit(i)]);
    assign stb.maskVal[i] = wrData[srcBit(i)];
  end

  // R6
  force_a_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (forceA && !pendA) |-> !stb.setFlag[SRC_CMPA]);
  // R6
  force_b_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (forceB && !pendB) |-> !stb.setFlag[SRC_CMPB]);
  // R5
  cmp_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.setFlag[SRC_CMPA] || stb.setFlag[SRC_CMPB]) |-> tick);
  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pendA) && $stable(pendB)));
endmodule

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobes_t         stb,
  input  logic             addrSel,
  input  logic             globalIe,
  output logic [REG_W-1:0] rdData,
  output logic [NSRC-1:0]  irq
);
  localparam logic [REG_W-1:0] VALID = validMask();

  logic [NSRC-1:0] flag;
  logic [NSRC-1:0] mask;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag[i] <= 1'b0;
      else if (stb.setFlag[i])   flag[i] <= 1'b1;
      else if (stb.clrFlag[i])   flag[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask[i] <= 1'b0;
      else if (stb.maskWe) mask[i] <= stb.maskVal[i];
    end

    assign irq[i] = flag[i] && mask[i] && globalIe;

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb.setFlag[i] |=> flag[i]);
    // R9
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.clrFlag[i] && !stb.setFlag[i]) |=> !flag[i]);
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NSRC; i++)
      rdData[srcBit(i)] = addrSel ? mask[i] : flag[i];
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData & ~VALID) == '0);
  // R4
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !globalIe |-> (irq == '0));
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic       addrSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       tick,
  input  logic       ovfPulse,
  input  logic       matchA,
  input  logic       matchB,
  input  logic       forceA,
  input  logic       forceB,
  input  logic       capEvent,
  input  logic       atTop,
  input  logic       capIsTop,
  input  logic       globalIe,
  input  logic       ackOvf,
  input  logic       ackCmpA,
  input  logic       ackCmpB,
  input  logic       ackCap,
  output logic       irqOvf,
  output logic       irqCmpA,
  output logic       irqCmpB,
  output logic       irqCap
);
  strobes_t        stb;
  logic [NSRC-1:0] ackVec;
  logic [NSRC-1:0] irqVec;

  assign ackVec[SRC_OVF]  = ackOvf;
  assign ackVec[SRC_CMPA] = ackCmpA;
  assign ackVec[SRC_CMPB] = ackCmpB;
  assign ackVec[SRC_CAP]  = ackCap;

  assign irqOvf  = irqVec[SRC_OVF];
  assign irqCmpA = irqVec[SRC_CMPA];
  assign irqCmpB = irqVec[SRC_CMPB];
  assign irqCap  = irqVec[SRC_CAP];

  tmr_irq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ovfPulse(ovfPulse),
    .matchA(matchA), .matchB(matchB), .forceA(forceA), .forceB(forceB),
    .capEvent(capEvent), .atTop(atTop), .capIsTop(capIsTop),
    .wrEn(wrEn), .addrSel(addrSel), .wrData(wrData), .ack(ackVec),
    .stb(stb)
  );

  tmr_irq_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .addrSel(addrSel),
    .globalIe(globalIe), .rdData(rdData), .irq(irqVec)
  );
endmodule

// File: tb/tmr_irq_unit_bench.sv
module tmr_irq_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 0, addrSel = 0;
  logic [7:0] wrData = 0;
  logic tick = 0, ovfPulse = 0, matchA = 0, matchB = 0, forceA = 0, forceB = 0;
  logic capEvent = 0, atTop = 0, capIsTop = 0, globalIe = 0;
  logic ackOvf = 0, ackCmpA = 0, ackCmpB = 0, ackCap = 0;
  logic [7:0] rdData;
  logic irqOvf, irqCmpA, irqCmpB, irqCap;

  int nChecks = 0, nFails = 0, cycles = 0;
  logic [3:0] mFlag = 0, mMask = 0;
  logic mPendA = 0, mPendB = 0;

  always #4 clk = ~clk;

  tmr_irq_unit u_tmr_irq_unit (.*);

  function automatic int bpos(input int s);
    return (s == 3) ? 5 : s;
  endfunction

  function automatic logic [7:0] packReg(input logic [3:0] v);
    logic [7:0] r = 8'h00;
    for (int s = 0; s < 4; s++) r[bpos(s)] = v[s];
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // model next state from the inputs currently driven
  task automatic modelStep();
    logic [3:0] setv, clrv, ackv;
    ackv = {ackCap, ackCmpB, ackCmpA, ackOvf};
    setv[0] = tick & ovfPulse;
    setv[1] = tick & mPendA;
    setv[2] = tick & mPendB;
    setv[3] = capIsTop ? (tick & atTop) : capEvent;
    for (int s = 0; s < 4; s++) clrv[s] = ackv[s] | (wrEn & ~addrSel & wrData[bpos(s)]);
    mFlag = setv | (mFlag & ~clrv);
    if (wrEn && addrSel)
      for (int s = 0; s < 4; s++) mMask[s] = wrData[bpos(s)];
    if (tick) begin
      mPendA = matchA;
      mPendB = matchB;
    end
  endtask

  task automatic step();
    modelStep();
    @(negedge clk);
    cycles++;
    chk("R4", {4'h0, irqCap, irqCmpB, irqCmpA, irqOvf}, {4'h0, mFlag & mMask & {4{globalIe}}});
    chk(addrSel ? "R3" : "R2", rdData, packReg(addrSel ? mMask : mFlag));
  endtask

  task automatic idle();
    wrEn = 0; tick = 0; ovfPulse = 0; matchA = 0; matchB = 0; forceA = 0; forceB = 0;
    capEvent = 0; atTop = 0; ackOvf = 0; ackCmpA = 0; ackCmpB = 0; ackCap = 0;
  endtask

  task automatic readReg(input logic a, output logic [7:0] v);
    addrSel = a; #1; v = rdData;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    readReg(0, v); chk("R1", v, 8'h00);
    readReg(1, v); chk("R1", v, 8'h00);
    chk("R1", {4'h0, irqCap, irqCmpB, irqCmpA, irqOvf}, 8'h00);

    // R3 enable layout: write all ones, read 0x27
    wrEn = 1; addrSel = 1; wrData = 8'hFF; step(); idle();
    readReg(1, v); chk("R3", v, 8'h27);

    // R5 compare A: match on tick, gap without tick, flag on next tick
    addrSel = 0; tick = 1; matchA = 1; step(); idle();
    step(); readReg(0, v); chk("R5", v, 8'h00);
    tick = 1; step(); idle(); readReg(0, v); chk("R5", v, 8'h02);
    // R5 match without tick is not sampled
    matchB = 1; step(); idle(); tick = 1; step(); idle();
    readReg(0, v); chk("R5", v, 8'h02);

    // R6 forced strobes alone never set compare flags
    tick = 1; forceA = 1; forceB = 1; step(); idle();
    tick = 1; forceA = 1; forceB = 1; step(); idle();
    readReg(0, v); chk("R6", v, 8'h02);

    // R7 overflow only on tick
    ovfPulse = 1; step(); idle(); readReg(0, v); chk("R7", v, 8'h02);
    ovfPulse = 1; tick = 1; step(); idle(); readReg(0, v); chk("R7", v, 8'h03);

    // R4 gating by global enable
    globalIe = 0; #1; chk("R4", {7'h0, irqCmpA}, 8'h00);
    globalIe = 1; #1; chk("R4", {6'h0, irqCmpA, irqOvf}, 8'h03);

    // R9 writing zero no effect; writing one clears
    wrEn = 1; addrSel = 0; wrData = 8'h00; step(); idle();
    readReg(0, v); chk("R9", v, 8'h03);
    wrEn = 1; addrSel = 0; wrData = 8'h01; step(); idle();
    readReg(0, v); chk("R9", v, 8'h02);

    // R10 acknowledge clears
    ackCmpA = 1; step(); idle(); readReg(0, v); chk("R10", v, 8'h00);

    // R8 capture modes
    capIsTop = 0; atTop = 1; tick = 1; step(); idle(); readReg(0, v); chk("R8", v, 8'h00);
    capEvent = 1; step(); idle(); readReg(0, v); chk("R8", v, 8'h20);
    ackCap = 1; step(); idle();
    capIsTop = 1; capEvent = 1; tick = 1; step(); idle(); readReg(0, v); chk("R8", v, 8'h00);
    atTop = 1; step(); idle(); readReg(0, v); chk("R8", v, 8'h00);
    atTop = 1; tick = 1; step(); idle(); readReg(0, v); chk("R8", v, 8'h20);

    // R11 set beats ack and write-one in the same cycle
    atTop = 1; tick = 1; ackCap = 1; wrEn = 1; addrSel = 0; wrData = 8'hFF; step(); idle();
    readReg(0, v); chk("R11", v, 8'h20);

    // R2 reserved bits read zero after writing ones
    wrEn = 1; addrSel = 0; wrData = 8'hFF; step(); idle();
    readReg(0, v); chk("R2", v, 8'h00);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      tick = r[0] | r[1];
      ovfPulse = r[2] & r[3];
      matchA = r[4]; matchB = r[5];
      forceA = r[6] & r[7]; forceB = r[8] & r[9];
      capEvent = r[10] & r[11];
      atTop = r[12] & r[13];
      if (r[31:28] == 0) capIsTop = ~capIsTop;
      globalIe = r[14] | r[15];
      ackOvf = (r[18:16] == 0); ackCmpA = (r[20:18] == 1);
      ackCmpB = (r[22:20] == 2); ackCap = (r[24:22] == 3);
      wrEn = (r[27:25] == 0);
      addrSel = r[26] & r[27] ? 1'b1 : r[25];
      wrData = 8'($urandom);
      step();
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule